// File: doc/BRIEF.md
# I2C Controller Interrupt Unit

This block gathers the event sources of an I2C controller into one twelve-bit status word, gates it with a mask word of the same layout, and drives one interrupt line. Ten of the sources are single-cycle pulses from the bus engine and FIFOs. Each pulse sets a sticky bit that stays set until software clears it. The other two sources are level conditions. They are computed from the live TX and RX FIFO fill levels against thresholds that software programs.

Software reaches the block through a simple single-cycle register port. Read data is combinational in the cycle of the request. Sticky bits are cleared by *reading* clear addresses, not by writing ones: one address clears every sticky bit, and one address per source clears a single bit. The abort event also accumulates a cause word. This word is cleared together with the abort bit.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After reset, the raw status, mask, masked status, both thresholds and the abort cause word read 0, and `irq_o` is low. The bench holds the RX level at 0 and the TX level at 16 during this check.
- R2: Status bit positions are: 0 RX underflow, 1 RX overflow, 2 RX threshold, 3 TX overflow, 4 TX threshold, 5 read request, 6 abort, 7 RX done, 8 activity, 9 stop, 10 start, 11 general call. A pulse on `evt_i[k]` sets raw status bit k (read at address 0) for every k except 2 and 4. Pulses on `evt_i[2]` and `evt_i[4]` are ignored.
- R3: A sticky bit stays set until a clear read, whatever the mask holds.
- R4: The mask is read and written at address 1, using bits 11:0. Address 2 reads raw status AND mask. `irq_o` is high exactly when that value is nonzero.
- R5: The RX threshold is read and written at address 3, using bits 3:0. Status bit 2 is 1 exactly when the RX level is greater than this threshold.
- R6: The TX threshold is read and written at address 4, using bits 3:0. Status bit 4 is 1 exactly when the TX level is less than or equal to this threshold.
- R7: Status bits 2 and 4 follow the FIFO levels every cycle, and clear reads do not affect them.
- R8: A read of address 5 returns the raw status and clears every sticky bit and the abort cause word.
- R9: A read of address 16+k returns raw status bit k in bit 0 and clears only sticky bit k. For k = 2 or k = 4 it clears nothing.
- R10: Each abort pulse ORs `abort_src_i` into the cause word, which is read at address 6. A read of address 22 clears the cause word together with status bit 6.
- R11: An event pulse in the same cycle as a clear read of its bit leaves the bit set.
- R12: Writes to addresses 0, 2, 5, 6 and 16 to 27 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the request cycle |
| evt_i | input | 12 | Event pulses at status bit positions |
| abort_src_i | input | 16 | Abort cause bits, sampled with `evt_i[6]` |
| rx_level_i | input | 5 | RX FIFO fill level, 0 to 16 |
| tx_level_i | input | 5 | TX FIFO fill level, 0 to 16 |
| irq_o | output | 1 | Masked interrupt |

## Verification
The threshold compare is swept exhaustively. Every threshold from 0 to 15 is paired with every fill level from 0 to 16, for both RX and TX. This separates strict from non-strict comparison and shows any off-by-one at the extremes.

Each of the twelve event lines is pulsed alone. This confirms bit placement and confirms that the two level positions ignore pulses. Each per-bit clear is then applied with all other bits set, which shows whether a clear leaks into neighbouring bits.

Mask patterns show how the interrupt line follows the masked status. The bench also covers a clear read colliding with a new event, and abort causes accumulating across two pulses.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int unsigned N_EVT  = 12;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;

  localparam int unsigned B_RXTH = 2;
  localparam int unsigned B_TXTH = 4;
  localparam int unsigned B_ABRT = 6;

  // sticky sources: every bit except the two level conditions
  localparam logic [N_EVT-1:0] EDGE_MASK = 12'hFEB;

  localparam logic [ADDR_W-1:0] A_RAW     = 5'd0;
  localparam logic [ADDR_W-1:0] A_MASK    = 5'd1;
  localparam logic [ADDR_W-1:0] A_MSTAT   = 5'd2;
  localparam logic [ADDR_W-1:0] A_RXTHR   = 5'd3;
  localparam logic [ADDR_W-1:0] A_TXTHR   = 5'd4;
  localparam logic [ADDR_W-1:0] A_CLRALL  = 5'd5;
  localparam logic [ADDR_W-1:0] A_ABRTSRC = 5'd6;
  localparam logic [ADDR_W-1:0] A_CLRBASE = 5'd16;
endpackage

// File: rtl/i2c_irq_decode.sv
module i2c_irq_decode
  import i2c_irq_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_mask_o,
  output logic              wr_rxthr_o,
  output logic              wr_txthr_o,
  output logic              clr_all_o,
  output logic [N_EVT-1:0]  clr_one_o
);
  logic rd_en, wr_en;

  assign rd_en = req_i & ~we_i;
  assign wr_en = req_i & we_i;

  assign wr_mask_o  = wr_en && (addr_i == A_MASK);
  assign wr_rxthr_o = wr_en && (addr_i == A_RXTHR);
  assign wr_txthr_o = wr_en && (addr_i == A_TXTHR);
  assign clr_all_o  = rd_en && (addr_i == A_CLRALL);

  for (genvar k = 0; k < N_EVT; k++) begin : g_clr
    assign clr_one_o[k] = rd_en && (addr_i == A_CLRBASE + ADDR_W'(k));
  end
endmodule

// File: rtl/i2c_irq_thresh.sv
module i2c_irq_thresh #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1),
  localparam int unsigned THR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_rx_i,
  input  logic             wr_tx_i,
  input  logic [THR_W-1:0] wdata_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_level_i,
  output logic [THR_W-1:0] rx_thr_o,
  output logic [THR_W-1:0] tx_thr_o,
  output logic             rx_hit_o,
  output logic             tx_hit_o
);
  logic [THR_W-1:0] rx_thr_q, tx_thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_thr_q <= '0;
      tx_thr_q <= '0;
    end else begin
      if (wr_rx_i) rx_thr_q <= wdata_i;
      if (wr_tx_i) tx_thr_q <= wdata_i;
    end
  end

  assign rx_thr_o = rx_thr_q;
  assign tx_thr_o = tx_thr_q;
  // threshold N-1 fires once N entries are present
  assign rx_hit_o = rx_level_i >  LVL_W'(rx_thr_q);
  assign tx_hit_o = tx_level_i <= LVL_W'(tx_thr_q);
endmodule

// File: rtl/i2c_irq_latch.sv
module i2c_irq_latch #(
  parameter int unsigned N     = 12,
  parameter logic [N-1:0] EDGE = '1,
  parameter int unsigned SRC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     set_i,
  input  logic [N-1:0]     clr_i,
  input  logic             abrt_set_i,
  input  logic [SRC_W-1:0] abrt_src_i,
  input  logic             abrt_clr_i,
  output logic [N-1:0]     lat_o,
  output logic [SRC_W-1:0] abrt_src_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    if (EDGE[k]) begin : g_sticky
      logic q;
      // set has priority so a colliding event is never lost
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[k]) q <= 1'b1;
        else if (clr_i[k]) q <= 1'b0;
      end
      assign lat_o[k] = q;
    end else begin : g_level
      assign lat_o[k] = 1'b0;
    end
  end

  logic [SRC_W-1:0] src_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= (abrt_clr_i ? '0 : src_q) | (abrt_set_i ? abrt_src_i : '0);
  end
  assign abrt_src_o = src_q;
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SRC_W = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1),
  localparam int unsigned THR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic [SRC_W-1:0]  abort_src_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  output logic              irq_o
);
  logic             wr_mask, wr_rxthr, wr_txthr, clr_all;
  logic [N_EVT-1:0] clr_one, clr_vec, lat_q, raw_stat, mask_q, mstat;
  logic [THR_W-1:0] rx_thr, tx_thr;
  logic             rx_hit, tx_hit;
  logic [SRC_W-1:0] abrt_src;

  i2c_irq_decode u_dec (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wr_mask_o (wr_mask),
    .wr_rxthr_o(wr_rxthr),
    .wr_txthr_o(wr_txthr),
    .clr_all_o (clr_all),
    .clr_one_o (clr_one)
  );

  i2c_irq_thresh #(.DEPTH(DEPTH)) u_thr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_rx_i   (wr_rxthr),
    .wr_tx_i   (wr_txthr),
    .wdata_i   (wdata_i[THR_W-1:0]),
    .rx_level_i(rx_level_i),
    .tx_level_i(tx_level_i),
    .rx_thr_o  (rx_thr),
    .tx_thr_o  (tx_thr),
    .rx_hit_o  (rx_hit),
    .tx_hit_o  (tx_hit)
  );

  assign clr_vec = {N_EVT{clr_all}} | clr_one;

  i2c_irq_latch #(.N(N_EVT), .EDGE(EDGE_MASK), .SRC_W(SRC_W)) u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (evt_i & EDGE_MASK),
    .clr_i     (clr_vec),
    .abrt_set_i(evt_i[B_ABRT]),
    .abrt_src_i(abort_src_i),
    .abrt_clr_i(clr_vec[B_ABRT]),
    .lat_o     (lat_q),
    .abrt_src_o(abrt_src)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_mask) mask_q <= wdata_i[N_EVT-1:0];
  end

  always_comb begin
    raw_stat         = lat_q;
    raw_stat[B_RXTH] = rx_hit;
    raw_stat[B_TXTH] = tx_hit;
  end

  assign mstat = raw_stat & mask_q;
  assign irq_o = |mstat;

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (addr_i >= A_CLRBASE && addr_i < A_CLRBASE + ADDR_W'(N_EVT)) begin
        rdata_o[0] = raw_stat[addr_i - A_CLRBASE];
      end else begin
        unique case (addr_i)
          A_RAW, A_CLRALL: rdata_o = DATA_W'(raw_stat);
          A_MASK:          rdata_o = DATA_W'(mask_q);
          A_MSTAT:         rdata_o = DATA_W'(mstat);
          A_RXTHR:         rdata_o = DATA_W'(rx_thr);
          A_TXTHR:         rdata_o = DATA_W'(tx_thr);
          A_ABRTSRC:       rdata_o = DATA_W'(abrt_src);
          default:         rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_irq_ctrl_chk.sv
module i2c_irq_ctrl_chk
  import i2c_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SRC_W = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_EVT-1:0]  evt_i,
  input logic [LVL_W-1:0]  rx_level_i,
  input logic [LVL_W-1:0]  tx_level_i,
  input logic              irq_o,
  input logic [N_EVT-1:0]  raw_stat,
  input logic [N_EVT-1:0]  lat_q,
  input logic [N_EVT-1:0]  clr_vec,
  input logic [SRC_W-1:0]  abrt_src
);
  // R3
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(lat_q) & ~$past(clr_vec)) & ~lat_q) == '0));

  // R4
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == A_MSTAT) |-> ((rdata_o != '0) == irq_o));

  // R5
  rx_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_level_i == '0) |-> !raw_stat[B_RXTH]);

  // R5
  rx_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_level_i == LVL_W'(DEPTH)) |-> raw_stat[B_RXTH]);

  // R6
  tx_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_i == '0) |-> raw_stat[B_TXTH]);

  // R6
  tx_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_i == LVL_W'(DEPTH)) |-> !raw_stat[B_TXTH]);

  // R8
  clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == A_CLRALL && ((evt_i & EDGE_MASK) == '0)) |=> (lat_q == '0));

  // R10
  abort_src_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (addr_i == A_CLRALL || addr_i == A_CLRBASE + ADDR_W'(B_ABRT))
     && !evt_i[B_ABRT]) |=> (abrt_src == '0));

  // R11
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(evt_i) & EDGE_MASK) & ~lat_q) == '0));
endmodule

bind i2c_irq_ctrl i2c_irq_ctrl_chk #(.DEPTH(DEPTH), .SRC_W(SRC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .evt_i     (evt_i),
  .rx_level_i(rx_level_i),
  .tx_level_i(tx_level_i),
  .irq_o     (irq_o),
  .raw_stat  (raw_stat),
  .lat_q     (lat_q),
  .clr_vec   (clr_vec),
  .abrt_src  (abrt_src)
);

// File: tb/i2c_irq_ctrl_test.sv
module i2c_irq_ctrl_test;
  localparam int unsigned DEPTH = 16;
  localparam logic [11:0] EDGE = 12'hFEB;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [11:0] evt_i = '0;
  logic [15:0] abort_src_i = '0;
  logic [4:0]  rx_level_i = '0;
  logic [4:0]  tx_level_i = 5'd16;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  i2c_irq_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i),
    .abort_src_i(abort_src_i), .rx_level_i(rx_level_i),
    .tx_level_i(tx_level_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic pulse(input logic [11:0] e, input logic [15:0] src);
    @(negedge clk_i);
    evt_i = e; abort_src_i = src;
    @(negedge clk_i);
    evt_i = '0; abort_src_i = '0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk_i);
      cyc++;
    end
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(5'd0, d); chk("R1 raw", d, 0);
    rd(5'd1, d); chk("R1 mask", d, 0);
    rd(5'd2, d); chk("R1 mstat", d, 0);
    rd(5'd3, d); chk("R1 rxthr", d, 0);
    rd(5'd4, d); chk("R1 txthr", d, 0);
    rd(5'd6, d); chk("R1 abrtsrc", d, 0);
    chk("R1 irq", irq_o, 0);

    // R2 placement, R9 single clear
    for (int k = 0; k < 12; k++) begin
      pulse(12'(1 << k), 16'h0);
      rd(5'd0, d); chk("R2 placement", d, EDGE[k] ? (1 << k) : 0);
      rd(5'(16 + k), d); chk("R9 clear read value", d, EDGE[k] ? 1 : 0);
      rd(5'd0, d); chk("R9 cleared", d, 0);
    end

    // R9 clear touches only its own bit; R3 sticky with mask 0
    for (int k = 0; k < 12; k++) begin
      pulse(EDGE, 16'h0);
      repeat (3) @(negedge clk_i);
      rd(5'd0, d); chk("R3 sticky", d, EDGE);
      rd(5'(16 + k), d);
      rd(5'd0, d); chk("R9 isolation", d, EDGE & ~(12'(1 << k)));
      rd(5'd5, d); chk("R8 clear-all value", d, EDGE & ~(12'(1 << k)));
      rd(5'd0, d); chk("R8 clear-all", d, 0);
    end

    // R4 mask and irq
    pulse(EDGE, 16'h0);
    for (int m = 0; m < 12; m++) begin
      wr(5'd1, 16'(1 << m));
      rd(5'd1, d); chk("R4 mask readback", d, 1 << m);
      rd(5'd2, d); chk("R4 mstat", d, EDGE & 12'(1 << m));
      @(negedge clk_i); #1 chk("R4 irq", irq_o, EDGE[m]);
    end
    wr(5'd1, 16'hFFFF);
    rd(5'd1, d); chk("R4 mask width", d, 16'h0FFF);
    rd(5'd5, d);
    @(negedge clk_i); #1 chk("R4 irq after clear", irq_o, 0);
    wr(5'd1, 16'h0);

    // R5 RX threshold sweep
    for (int t = 0; t < 16; t++) begin
      wr(5'd3, 16'(t));
      rd(5'd3, d); chk("R5 rxthr readback", d, t);
      for (int l = 0; l <= 16; l++) begin
        @(negedge clk_i); rx_level_i = 5'(l);
        rd(5'd0, d); chk("R5 rx threshold", d[2], (l > t));
      end
    end
    rx_level_i = '0;

    // R6 TX threshold sweep
    for (int t = 0; t < 16; t++) begin
      wr(5'd4, 16'(t));
      rd(5'd4, d); chk("R6 txthr readback", d, t);
      for (int l = 0; l <= 16; l++) begin
        @(negedge clk_i); tx_level_i = 5'(l);
        rd(5'd0, d); chk("R6 tx threshold", d[4], (l <= t));
      end
    end
    tx_level_i = 5'd16;

    // R7 level bits immune to clears
    wr(5'd3, 16'd0); wr(5'd4, 16'd15);
    @(negedge clk_i); rx_level_i = 5'd16; tx_level_i = 5'd0;
    rd(5'd5, d); rd(5'd18, d); rd(5'd20, d);
    rd(5'd0, d); chk("R7 level bits kept", d, 12'h014);
    wr(5'd1, 16'h0004);
    @(negedge clk_i); #1 chk("R7 irq from level", irq_o, 1);
    @(negedge clk_i); rx_level_i = 5'd0; tx_level_i = 5'd16;
    #1 chk("R7 level bits follow", irq_o, 0);
    wr(5'd1, 16'h0);

    // R10 abort cause accumulate and clear
    pulse(12'h040, 16'h0005);
    pulse(12'h040, 16'h0100);
    rd(5'd6, d); chk("R10 cause accumulate", d, 16'h0105);
    rd(5'd22, d); chk("R10 abort clear value", d, 1);
    rd(5'd6, d); chk("R10 cause cleared", d, 0);
    rd(5'd0, d); chk("R10 abort bit cleared", d, 0);
    pulse(12'h040, 16'h8000);
    rd(5'd5, d);
    rd(5'd6, d); chk("R8 clear-all cause", d, 0);

    // R11 event colliding with clear
    pulse(12'h002, 16'h0);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = 5'd17; evt_i = 12'h002;
    @(negedge clk_i);
    req_i = 1'b0; evt_i = '0;
    rd(5'd0, d); chk("R11 single clear collision", d, 12'h002);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = 5'd5; evt_i = 12'h800;
    @(negedge clk_i);
    req_i = 1'b0; evt_i = '0;
    rd(5'd0, d); chk("R11 clear-all collision", d, 12'h800);
    rd(5'd5, d);

    // R12 writes to non-writable addresses
    pulse(EDGE, 16'h00F0);
    wr(5'd0, 16'h0000); wr(5'd2, 16'h0000); wr(5'd5, 16'hFFFF);
    wr(5'd6, 16'h0000);
    for (int k = 16; k < 28; k++) wr(5'(k), 16'hFFFF);
    rd(5'd0, d); chk("R12 raw unchanged", d, EDGE);
    rd(5'd6, d); chk("R12 cause unchanged", d, 16'h00F0);
    rd(5'd1, d); chk("R12 mask unchanged", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule